// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Clock Pass-Through

This block generates two independent pulse-width modulated outputs. Software programs it through a small word-addressed write/read bus. Each channel slows the module clock with a power-of-two divider and advances a period counter on every divided tick. The output is at its active level while the count is below the programmed active count, and at the opposite level for the rest of the period.

All per-channel mode controls share one control word, one byte per channel. Each channel also has its own word that holds its active count and its period length. A new period or active count is first held in a shadow copy and is applied only when the running period wraps, so the waveform never carries a truncated cycle. A pass-through bit per channel takes priority over every other setting, including enable, and routes the module clock straight to that channel's output pin.

Top module: `pwm_dual`

## Requirements
- R1: The register window is 0x400 bytes and is decoded by word index `bus_addr[9:2]`. Word 0 is the control word; its byte c belongs to channel c and reads back zero-extended. Words 1 and 2 are the timing words of channels 0 and 1. Any other word reads 0 and ignores writes. A read of a timing word returns the last value written to it.
- R2: While bit 7 (pass-through) of a channel's control byte is set, that channel's output equals the module clock, whatever the enable, gate, polarity, divider and timing settings are.
- R3: Setting pass-through abandons the running period at once. The period counter is zero from the next cycle on, and a channel that leaves pass-through while enabled starts a fresh period at count 0.
- R4: Bits 3:0 of the control byte pick the divider. Code 15 advances the counter on every clock. Code k below 15 advances it once every 2^(k+1) clocks.
- R5: Bit 5 (gate) clear stops the divider and the period counter of an enabled channel, so the output holds its level. Setting the gate again resumes counting from the held state.
- R6: A timing word holds the active count D in bits 15:0 and the period code P in bits 31:16. One period lasts P+1 divided ticks, with count values 0 to P, and the output is active while the count is below D.
- R7: Bit 6 selects the active level. Set drives 1 during the active part and 0 otherwise; clear inverts both levels.
- R8: A timing-word write to an enabled channel that is not in pass-through takes effect only after the counter wraps from P to 0. While a channel is disabled or in pass-through, the applied values follow the written ones.
- R9: With bit 4 (enable) clear and pass-through clear, the output sits at the inactive level, the inverse of bit 6. After reset every control bit is 0, so both outputs are 1.
- R10: When the applied D is greater than or equal to the applied P, the output stays at the active level for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module source clock; also forwarded in pass-through |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 10 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 2 | Channel outputs, bit c for channel c |

## Verification
The bench builds the block with its default parameters: two channels, 16-bit counts and a 10-bit address. These values reach the undivided code, the divide-by-2 and divide-by-4 codes, the whole window decode including the last word, and the collision of the two channel bytes inside one control word. Because the counts are small, many periods fit in a short run. A shadowed write lands at several points of a running period, and the active count passes through below, equal to and above the period code. The output is compared at both clock levels, so the clock-forwarding path of pass-through is observed directly.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
    localparam int PS_W    = 4;
    localparam int FIELD_W = 8;

    typedef struct packed {
        logic            byp;
        logic            act;
        logic            gate;
        logic            en;
        logic [PS_W-1:0] ps;
    } chan_ctrl_t;
endpackage

// File: rtl/pwm_dual_regbank.sv
module pwm_dual_regbank
    import pwm_dual_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = 16,
    parameter int AW  = 10,
    parameter int DW  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [DW-1:0]            wdata,
    output logic [DW-1:0]            rdata,
    output chan_ctrl_t [NCH-1:0]     ctrl_o,
    output logic [NCH-1:0][CW-1:0]   duty_o,
    output logic [NCH-1:0][CW-1:0]   per_o
);
    localparam int IDXW    = AW - 2;
    localparam int PER_LSB = DW / 2;
    localparam int CTRL_W  = NCH * FIELD_W;

    typedef struct packed {
        chan_ctrl_t [NCH-1:0]   ctrl;
        logic [NCH-1:0][CW-1:0] duty;
        logic [NCH-1:0][CW-1:0] per;
    } bank_t;

    bank_t           s_d, s_q;
    logic [IDXW-1:0] idx;

    assign idx = addr[AW-1:2];

    always_comb begin
        s_d   = s_q;
        rdata = '0;
        if (we && idx == '0) begin
            s_d.ctrl = wdata[CTRL_W-1:0];
        end
        if (idx == '0) begin
            rdata[CTRL_W-1:0] = s_q.ctrl;
        end
        for (int c = 0; c < NCH; c++) begin
            if (idx == IDXW'(c + 1)) begin
                if (we) begin
                    s_d.duty[c] = wdata[CW-1:0];
                    s_d.per[c]  = wdata[PER_LSB +: CW];
                end
                rdata[CW-1:0]         = s_q.duty[c];
                rdata[PER_LSB +: CW]  = s_q.per[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o = s_q.ctrl;
    assign duty_o = s_q.duty;
    assign per_o  = s_q.per;
endmodule

// File: rtl/pwm_dual_prescaler.sv
module pwm_dual_prescaler
    import pwm_dual_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic [PS_W-1:0] code,
    output logic            tick
);
    localparam int DIVW = (1 << PS_W) - 1;

    typedef struct packed {
        logic [DIVW-1:0] pc;
    } div_t;

    div_t          s_d, s_q;
    logic [DIVW:0] div_len;

    always_comb begin
        s_d = s_q;
        if (code == '1) div_len = (DIVW+1)'(1);
        else            div_len = (DIVW+1)'(1) << ({1'b0, code} + (PS_W+1)'(1));
        tick = run && ({1'b0, s_q.pc} >= div_len - (DIVW+1)'(1));
        if (clr)       s_d.pc = '0;
        else if (tick) s_d.pc = '0;
        else if (run)  s_d.pc = s_q.pc + DIVW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pwm_dual_channel.sv
module pwm_dual_channel
    import pwm_dual_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_ctrl_t    ctrl,
    input  logic [CW-1:0] duty_sh,
    input  logic [CW-1:0] per_sh,
    output logic          pwm_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] per_act_o,
    output logic          tick_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] duty_a;
        logic [CW-1:0] per_a;
    } chan_t;

    chan_t s_d, s_q;
    logic  run, clr, tick, active, level;

    assign run = ctrl.en && ctrl.gate && !ctrl.byp;
    assign clr = !ctrl.en || ctrl.byp;

    pwm_dual_prescaler u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (clr),
        .code  (ctrl.ps),
        .tick  (tick)
    );

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.cnt    = '0;
            s_d.duty_a = duty_sh;
            s_d.per_a  = per_sh;
        end else if (tick) begin
            if (s_q.cnt >= s_q.per_a) begin
                s_d.cnt    = '0;
                s_d.duty_a = duty_sh;
                s_d.per_a  = per_sh;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = (s_q.cnt < s_q.duty_a) || (s_q.duty_a >= s_q.per_a);
    assign level  = (ctrl.en && active) ? ctrl.act : !ctrl.act;
    assign pwm_o  = ctrl.byp ? clk : level;

    assign cnt_o     = s_q.cnt;
    assign per_act_o = s_q.per_a;
    assign tick_o    = tick;
endmodule

// File: rtl/pwm_dual.sv
module pwm_dual
    import pwm_dual_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = 16,
    parameter int AW  = 10,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] pwm_out
);
    chan_ctrl_t [NCH-1:0]   ctrl_all;
    logic [NCH-1:0][CW-1:0] duty_sh;
    logic [NCH-1:0][CW-1:0] per_sh;
    logic [NCH-1:0][CW-1:0] cnt_all;
    logic [NCH-1:0][CW-1:0] per_all;
    logic [NCH-1:0]         tick_all;

    pwm_dual_regbank #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctrl_o (ctrl_all),
        .duty_o (duty_sh),
        .per_o  (per_sh)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_dual_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl      (ctrl_all[c]),
            .duty_sh   (duty_sh[c]),
            .per_sh    (per_sh[c]),
            .pwm_o     (pwm_out[c]),
            .cnt_o     (cnt_all[c]),
            .per_act_o (per_all[c]),
            .tick_o    (tick_all[c])
        );
    end
endmodule

// File: rtl/pwm_dual_chk.sv
module pwm_dual_chk
    import pwm_dual_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input chan_ctrl_t [NCH-1:0]   ctrl,
    input logic [NCH-1:0][CW-1:0] cnt,
    input logic [NCH-1:0][CW-1:0] per_act,
    input logic [NCH-1:0]         tick,
    input logic [NCH-1:0]         pwm_out
);
    for (genvar c = 0; c < NCH; c++) begin : g_chk
        assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl[c].en && !ctrl[c].byp) |-> (pwm_out[c] == !ctrl[c].act));

        assert_bypass_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl[c].byp |=> (cnt[c] == '0));

        assert_gate_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[c].en && !ctrl[c].gate && !ctrl[c].byp) |=> $stable(cnt[c]));

        assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[c] <= per_act[c]);

        assert_undivided_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[c].ps == '1 && ctrl[c].en && ctrl[c].gate && !ctrl[c].byp) |-> tick[c]);

        assert_load_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl[c].en && !ctrl[c].byp && cnt[c] != per_act[c]) |=> $stable(per_act[c]));
    end
endmodule

bind pwm_dual pwm_dual_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl_all),
    .cnt     (cnt_all),
    .per_act (per_all),
    .tick    (tick_all),
    .pwm_out (pwm_out)
);

// File: tb/tb_pwm_dual.sv
`timescale 1ns/1ps
module tb_pwm_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;

    always #2.5 clk = ~clk;

    pwm_dual dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // behavioural reference
    int m_ctrl;
    int m_dsh[2], m_psh[2], m_da[2], m_pa[2], m_cnt[2], m_pc[2];

    function automatic int fld(int ch);
        return (m_ctrl >> (8 * ch)) & 255;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 0;
            for (int c = 0; c < 2; c++) begin
                m_dsh[c] = 0; m_psh[c] = 0; m_da[c] = 0;
                m_pa[c] = 0; m_cnt[c] = 0; m_pc[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                int f, dv;
                f = fld(c);
                if (((f >> 4) & 1) == 0 || ((f >> 7) & 1) == 1) begin
                    m_pc[c] = 0; m_cnt[c] = 0;
                    m_da[c] = m_dsh[c]; m_pa[c] = m_psh[c];
                end else if (((f >> 5) & 1) == 1) begin
                    dv = ((f & 15) == 15) ? 1 : (1 << ((f & 15) + 1));
                    if (m_pc[c] >= dv - 1) begin
                        m_pc[c] = 0;
                        if (m_cnt[c] >= m_pa[c]) begin
                            m_cnt[c] = 0;
                            m_da[c] = m_dsh[c]; m_pa[c] = m_psh[c];
                        end else m_cnt[c] = m_cnt[c] + 1;
                    end else m_pc[c] = m_pc[c] + 1;
                end
            end
            if (bus_we) begin
                int idx;
                idx = int'(bus_addr >> 2);
                if (idx == 0) m_ctrl = int'(bus_wdata & 32'hFFFF);
                else if (idx == 1 || idx == 2) begin
                    m_dsh[idx-1] = int'(bus_wdata & 32'hFFFF);
                    m_psh[idx-1] = int'(bus_wdata >> 16);
                end
            end
        end
    end

    function automatic bit exp_out(int ch, bit lvl);
        int f; bit act;
        f = fld(ch);
        act = ((f >> 6) & 1) == 1;
        if (((f >> 7) & 1) == 1) return lvl;
        if (((f >> 4) & 1) == 0) return !act;
        if (m_cnt[ch] < m_da[ch] || m_da[ch] >= m_pa[ch]) return act;
        return !act;
    endfunction

    function automatic string tag_of(int ch);
        int f;
        f = fld(ch);
        if (((f >> 7) & 1) == 1) return "R2";
        if (((f >> 4) & 1) == 0) return "R9";
        if (m_da[ch] >= m_pa[ch]) return "R10";
        return "R6/R7";
    endfunction

    task automatic cmp_out(bit lvl);
        for (int c = 0; c < 2; c++) begin
            bit e;
            e = exp_out(c, lvl);
            n_chk++;
            if (pwm_out[c] !== e) begin
                n_bad++;
                $display("FAIL %s ch%0d t=%0t pwm_out=%b expected %b", tag_of(c), c, $time, pwm_out[c], e);
            end
        end
    endtask

    always begin
        @(posedge clk); #1;
        if (chk_on) cmp_out(1'b1);
    end
    always begin
        @(negedge clk); #1;
        if (chk_on) cmp_out(1'b0);
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 10'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input int a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = 10'(a);
        #1;
        n_chk++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s read 0x%0h rdata=0x%0h expected 0x%0h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state: control word clear (R1), outputs inactive high (R9)
        rd_check(0, 32'h0, "R1");
        chk_on = 1'b1;
        run(2);

        // ch0: undivided (R4), P=4 D=2, active high
        wr(32'h004, {16'd4, 16'd2});
        wr(32'h000, 32'h0000_007F);
        run(25);
        // ch1: divide by 2, P=3 D=1, inverted level (R7)
        wr(32'h008, {16'd3, 16'd1});
        wr(32'h000, 32'h0000_307F);
        run(30);
        // shadowed timing update mid-period (R8)
        wr(32'h004, {16'd6, 16'd5});
        run(30);
        // gate ch1 off, change divider, gate back on (R5, R4)
        wr(32'h000, 32'h0000_107F);
        run(10);
        wr(32'h000, 32'h0000_117F);
        run(5);
        wr(32'h000, 32'h0000_317F);
        run(40);
        // duty equal to and above period (R10)
        wr(32'h004, {16'd6, 16'd6});
        run(20);
        wr(32'h004, {16'd6, 16'd9});
        run(20);
        wr(32'h004, {16'd5, 16'd2});
        run(9);
        // pass-through with enable cleared, cut mid-period (R2, R3)
        wr(32'h000, 32'h0000_318F);
        run(10);
        wr(32'h000, 32'h0000_317F);
        run(20);
        // register decode and readback (R1)
        rd_check(32'h000, 32'h0000_317F, "R1");
        rd_check(32'h004, {16'd5, 16'd2}, "R1");
        rd_check(32'h008, {16'd3, 16'd1}, "R1");
        wr(32'h014, 32'hDEAD_BEEF);
        wr(32'h3FC, 32'h1234_5678);
        rd_check(32'h014, 32'h0, "R1");
        rd_check(32'h3FC, 32'h0, "R1");
        rd_check(32'h000, 32'h0000_317F, "R1");
        rd_check(32'h006, {16'd5, 16'd2}, "R1");
        // disable ch1: inactive level (R9)
        wr(32'h000, 32'h0000_017F);
        run(10);
        // zero period and zero duty
        wr(32'h004, 32'h0);
        run(12);
        // pass-through while enabled on ch1 (R2)
        wr(32'h000, 32'h0000_F17F);
        run(8);
        chk_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule